// File: doc/BRIEF.md
# Low-Speed Serial Bus Reply Transmitter

This block turns a short reply packet into the differential line states of a low-speed serial bus. On a start strobe it first presents the idle state J while the output enable is still low. It then takes the bus and sends an internal sync byte followed by the payload bytes, least significant bit first. The line is NRZI coded, a stuffed zero follows every run of six ones, and the packet closes with two bit times of SE0 and one bit time of J. After that the bus is released with both line outputs at zero, so no pull-up is left driven.

Payload bytes are pulled through a one-cycle fetch strobe, one byte per strobe, during the last bit of the byte before it, so no gap appears between bytes. A shortcut input replaces the payload with a single acknowledge or negative-acknowledge PID. After a data packet, but never after such a handshake, a pending device address is copied into the active address register once the bus is released.

States: ST_IDLE (bus released), ST_PREP (J presented, enable low, one clock), ST_SEND (sync, payload and stuffed bits), ST_SE0 (two bit times) and ST_EOPJ (one bit time). Transitions: ST_IDLE to ST_PREP on an accepted start; ST_PREP to ST_SEND after one clock; ST_SEND to ST_SE0 at the bit boundary after the last bit, once any stuffed bit is out; ST_SE0 to ST_EOPJ after its second bit time; ST_EOPJ to ST_IDLE after one bit time.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset oe_o, dp_o, dm_o, busy_o and fetch_o are 0 and addr_o is 0.
- R2: A start_i seen in ST_IDLE raises busy_o on the next clock. For that one clock the lines show J (dp_o=0, dm_o=1) with oe_o low. From the following clock oe_o is high and the first sync bit is on the line.
- R3: Each bit lasts 8 clocks. J is dp_o=0, dm_o=1 and K is dp_o=1, dm_o=0. A 0 bit toggles the line state and a 1 bit holds it, starting from J. Both lines are never high together.
- R4: The sync byte 0x80 is sent first, then count_i-1 payload bytes in fetch order, each least significant bit first. count_i counts the sync byte and is at least 1.
- R5: After six consecutive 1 bits one extra toggle is inserted and the run restarts. This also applies when the run ends on the last payload bit.
- R6: fetch_o is a one-clock pulse, and byte_i is taken in that clock. There is exactly one pulse per payload byte, at the start of the last bit of the byte before it.
- R7: After the last bit the lines show SE0 (both 0) for 16 clocks and J for 8 clocks, with oe_o high. Then oe_o falls and dp_o and dm_o stay 0.
- R8: With hs_i high at start, the packet is the sync byte followed by PID 0xD2 (hs_nak_i=0) or 0x5A (hs_nak_i=1). count_i is ignored and no fetch_o pulse occurs.
- R9: When a data packet ends, addr_o takes new_addr_i at the clock on which oe_o is released. After a handshake packet addr_o is unchanged. addr_o never changes while busy_o is high.
- R10: busy_o stays high until oe_o is released. A start_i while busy_o is high is ignored and does not alter the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 8 per bus bit |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| count_i | input | CNT_W | Byte count including the sync byte |
| hs_i | input | 1 | Send a handshake PID instead of payload |
| hs_nak_i | input | 1 | Handshake choice: 1 negative, 0 positive |
| fetch_o | output | 1 | Next payload byte is taken this clock |
| byte_i | input | 8 | Payload byte, valid while fetch_o is high |
| new_addr_i | input | ADDR_W | Pending device address |
| dp_o | output | 1 | D+ line drive value |
| dm_o | output | 1 | D- line drive value |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| addr_o | output | ADDR_W | Active device address |

## Verification
The properties assume that count_i is at least 1 whenever a start is accepted, that byte_i holds the wanted byte in every clock where fetch_o is high, and that reset is applied before the first start. The bench meets these by using counts from 1 to 5 only and by serving byte_i combinationally from a small bench memory, indexed by the number of fetch pulses seen in the packet. Extra start pulses are sent only in the middle of a packet, never in the last clock of ST_EOPJ, so an ignored start cannot be mistaken for a fresh one.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SEND,
        ST_SE0,
        ST_EOPJ
    } tx_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;
endpackage

// File: rtl/usb_ls_tx_baud.sv
module usb_ls_tx_baud #(
    parameter int CLK_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PH_W = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_BIT - 1);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            ph <= '0;
        end else if (ph == PH_LAST) begin
            ph <= '0;
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    assign tick_o = run_i && (ph == PH_LAST);
endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic step_i,
    input  logic bit_i,
    output logic line_o,
    output logic stuff_due_o
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [RUN_W-1:0] run;

    assign stuff_due_o = (run == RUN_W'(STUFF_RUN));

    // line_o: 1 means J, 0 means K
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            line_o <= 1'b1;
            run    <= '0;
        end else if (step_i) begin
            if (stuff_due_o) begin
                line_o <= ~line_o;
                run    <= '0;
            end else if (bit_i) begin
                run    <= run + RUN_W'(1);
            end else begin
                line_o <= ~line_o;
                run    <= '0;
            end
        end
    end
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLK_PER_BIT = 8,
    parameter int CNT_W       = 8,
    parameter int ADDR_W      = 7,
    parameter int STUFF_RUN   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              hs_i,
    input  logic              hs_nak_i,
    output logic              fetch_o,
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] new_addr_i,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o
);
    tx_state_t        state, nxt;
    logic             tick, line, stuff_due;
    logic [7:0]       sh;
    logic [2:0]       bitc;
    logic [CNT_W-1:0] left;
    logic             fin, hs_q, se0_second;
    logic [7:0]       pid_q;
    logic             accept, boundary, consume, step, timer_run;

    assign accept    = (state == ST_IDLE) && start_i;
    assign boundary  = (state == ST_PREP) || ((state == ST_SEND) && tick);
    assign consume   = boundary && !stuff_due && !fin;
    assign step      = consume || (boundary && stuff_due);
    assign timer_run = (state == ST_SEND) || (state == ST_SE0) || (state == ST_EOPJ);
    assign fetch_o   = consume && (bitc == 3'd7) && (left != '0) && !hs_q;

    usb_ls_tx_baud #(.CLK_PER_BIT(CLK_PER_BIT)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .tick_o (tick)
    );

    usb_ls_tx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (accept),
        .step_i      (step),
        .bit_i       (sh[bitc]),
        .line_o      (line),
        .stuff_due_o (stuff_due)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_i) nxt = ST_PREP;
            ST_PREP: nxt = ST_SEND;
            ST_SEND: if (tick && !stuff_due && fin) nxt = ST_SE0;
            ST_SE0:  if (tick && se0_second) nxt = ST_EOPJ;
            ST_EOPJ: if (tick) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // bit and byte sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            bitc       <= '0;
            left       <= '0;
            fin        <= 1'b0;
            hs_q       <= 1'b0;
            pid_q      <= '0;
            se0_second <= 1'b0;
            addr_o     <= '0;
        end else begin
            if (accept) begin
                sh    <= SYNC_BYTE;
                bitc  <= '0;
                fin   <= 1'b0;
                hs_q  <= hs_i;
                pid_q <= hs_nak_i ? PID_NAK : PID_ACK;
                left  <= hs_i ? CNT_W'(1) : (count_i - CNT_W'(1));
            end
            if (consume) begin
                if (bitc == 3'd7) begin
                    bitc <= '0;
                    if (left != '0) begin
                        sh   <= hs_q ? pid_q : byte_i;
                        left <= left - CNT_W'(1);
                    end else begin
                        fin  <= 1'b1;
                    end
                end else begin
                    bitc <= bitc + 3'd1;
                end
            end
            if (state != ST_SE0) begin
                se0_second <= 1'b0;
            end else if (tick) begin
                se0_second <= 1'b1;
            end
            if ((state == ST_EOPJ) && tick && !hs_q) begin
                addr_o <= new_addr_i;
            end
        end
    end

    // outputs per state
    always_comb begin
        dp_o = 1'b0;
        dm_o = 1'b0;
        oe_o = 1'b0;
        unique case (state)
            ST_IDLE: begin dp_o = 1'b0;  dm_o = 1'b0; oe_o = 1'b0; end
            ST_PREP: begin dp_o = 1'b0;  dm_o = 1'b1; oe_o = 1'b0; end
            ST_SEND: begin dp_o = ~line; dm_o = line; oe_o = 1'b1; end
            ST_SE0:  begin dp_o = 1'b0;  dm_o = 1'b0; oe_o = 1'b1; end
            ST_EOPJ: begin dp_o = 1'b0;  dm_o = 1'b1; oe_o = 1'b1; end
            default: begin dp_o = 1'b0;  dm_o = 1'b0; oe_o = 1'b0; end
        endcase
    end

    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              hs_i,
    input logic              fetch_o,
    input logic              dp_o,
    input logic              dm_o,
    input logic              oe_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] addr_o
);
    logic hs_pkt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_pkt <= 1'b0;
        end else if (start_i && !busy_o) begin
            hs_pkt <= hs_i;
        end
    end

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> busy_o); // R10

    AST_OE_FROM_J: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> ($past(busy_o) && $past(dm_o) && !$past(dp_o))); // R2

    AST_NO_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_o && dm_o)); // R3

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> !fetch_o); // R6

    AST_RELEASE_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> ($past(dm_o) && !$past(dp_o) && !dp_o && !dm_o)); // R7

    AST_HS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_pkt && busy_o) |-> !fetch_o); // R8

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(addr_o)); // R9
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .hs_i    (hs_i),
    .fetch_o (fetch_o),
    .dp_o    (dp_o),
    .dm_o    (dm_o),
    .oe_o    (oe_o),
    .busy_o  (busy_o),
    .addr_o  (addr_o)
);

// File: tb/sim_usb_ls_tx.sv
module sim_usb_ls_tx;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] count_i = '0;
    logic       hs_i = 1'b0;
    logic       hs_nak_i = 1'b0;
    logic       fetch_o;
    logic [7:0] byte_i;
    logic [6:0] new_addr_i = '0;
    logic       dp_o, dm_o, oe_o, busy_o;
    logic [6:0] addr_o;

    int checks = 0;
    int errors = 0;
    int fcnt = 0;
    int fbase = 0;
    logic [7:0] mem [0:3];
    logic [6:0] exp_addr = '0;

    // entries: {count, payload0, payload1, payload2, payload3}
    localparam logic [39:0] PKTS [5] = '{
        {8'd3, 8'h00, 8'hA5, 8'h00, 8'h00},
        {8'd5, 8'hFF, 8'hFF, 8'h3F, 8'h12},
        {8'd1, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'd3, 8'h3F, 8'hFC, 8'h00, 8'h00},
        {8'd4, 8'h69, 8'h01, 8'h80, 8'h00}
    };

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) if (fetch_o) fcnt <= fcnt + 1;
    assign byte_i = mem[(fcnt - fbase) & 3];

    usb_ls_tx u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .hs_i(hs_i), .hs_nak_i(hs_nak_i), .fetch_o(fetch_o), .byte_i(byte_i),
        .new_addr_i(new_addr_i), .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o),
        .busy_o(busy_o), .addr_o(addr_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_pkt(input bit hs, input bit nak, input logic [7:0] cnt,
                           input logic [31:0] data, input logic [6:0] na, input bit poke);
        logic [7:0] bytes [0:4];
        bit         expj [0:127];
        int         nb, ns, run, f0;
        bit         line;
        string      tag;
        tag = hs ? "R8" : "R3 R4 R5";
        bytes[0] = 8'h80;
        if (hs) begin
            nb = 2;
            bytes[1] = nak ? 8'h5A : 8'hD2;
        end else begin
            nb = cnt;
            for (int i = 0; i < 4; i++) bytes[i+1] = data[31-8*i -: 8];
        end
        for (int i = 0; i < 4; i++) mem[i] = data[31-8*i -: 8];
        line = 1'b1; run = 0; ns = 0;
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 8; k++) begin
                if (bytes[b][k]) run++;
                else begin line = ~line; run = 0; end
                expj[ns] = line; ns++;
                if (run == 6) begin line = ~line; run = 0; expj[ns] = line; ns++; end
            end
        end
        fbase = fcnt;
        f0 = fcnt;
        @(negedge clk);
        start_i = 1'b1; count_i = hs ? 8'd9 : cnt; hs_i = hs; hs_nak_i = nak; new_addr_i = na;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !oe_o && !dp_o && dm_o, "R2 prep", {busy_o, oe_o, dp_o, dm_o}, 4'b1001);
        for (int s = 0; s < ns; s++) begin
            int w;
            w = (s == 0) ? 4 : 8;
            if (poke && s == 3) begin
                start_i = 1'b1; hs_i = 1'b1; count_i = 8'd2;
                @(negedge clk);
                start_i = 1'b0;
                w = w - 1;
            end
            repeat (w) @(negedge clk);
            check({oe_o, dp_o, dm_o} == {1'b1, ~expj[s], expj[s]},
                  poke ? "R10 ignored start" : tag,
                  {oe_o, dp_o, dm_o}, {1'b1, ~expj[s], expj[s]});
        end
        repeat (8) @(negedge clk);
        check({oe_o, dp_o, dm_o} == 3'b100, "R7 se0 first", {oe_o, dp_o, dm_o}, 3'b100);
        repeat (8) @(negedge clk);
        check({oe_o, dp_o, dm_o} == 3'b100, "R7 se0 second", {oe_o, dp_o, dm_o}, 3'b100);
        repeat (8) @(negedge clk);
        check({oe_o, dp_o, dm_o, busy_o} == 4'b1011, "R7 final J", {oe_o, dp_o, dm_o, busy_o}, 4'b1011);
        repeat (8) @(negedge clk);
        check({oe_o, dp_o, dm_o, busy_o} == 4'b0000, "R7 R10 released", {oe_o, dp_o, dm_o, busy_o}, 4'b0000);
        if (!hs) exp_addr = na;
        check(addr_o == exp_addr, "R9 address", addr_o, exp_addr);
        check((fcnt - f0) == (hs ? 0 : cnt - 1), hs ? "R8 no fetch" : "R6 fetch count",
              fcnt - f0, hs ? 0 : cnt - 1);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({oe_o, dp_o, dm_o, busy_o, fetch_o} == 5'b0 && addr_o == 7'd0, "R1 in reset",
              {oe_o, dp_o, dm_o, busy_o, fetch_o, addr_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({oe_o, dp_o, dm_o, busy_o, fetch_o} == 5'b0 && addr_o == 7'd0, "R1 after reset",
              {oe_o, dp_o, dm_o, busy_o, fetch_o, addr_o}, 0);

        for (int i = 0; i < 5; i++) begin
            run_pkt(1'b0, 1'b0, PKTS[i][39:32], PKTS[i][31:0], 7'(i * 9 + 3), i == 1);
        end

        // handshake packets leave the address alone
        run_pkt(1'b1, 1'b0, 8'd2, 32'hFFFF_FFFF, 7'h55, 1'b0);
        run_pkt(1'b1, 1'b1, 8'd2, 32'hFFFF_FFFF, 7'h2A, 1'b0);

        // start right after release is accepted again (R2)
        run_pkt(1'b0, 1'b0, 8'd2, 32'h7E00_0000, 7'h11, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule